// File: doc/BRIEF.md
# Hysteresis Sampled Frequency Meter

This block estimates the frequency of a periodic signal that arrives as a stream of signed ADC samples at a fixed, known sample rate. Each valid sample passes through a two-level comparator with hysteresis, which turns the noisy analog waveform into a clean binary level. A rising step of that level, found by comparing it with its value at the previous sample, marks the start of a new input period. A saturating counter measures how many samples separate successive rising steps. A sequential divider then turns the sample rate, divided by that interval, into a frequency in hertz.

To reduce the jitter that the one-sample time quantisation causes at high input frequencies, the block can sum the intervals of N consecutive periods and report one estimate per N rising steps. The frequency output holds its value between updates. A one-cycle strobe marks each new estimate. A no-signal flag reports that no estimate exists yet, or that the input has stopped toggling for longer than the counter can measure.

Top module: `hfm_freq_meter`

## Requirements
- R1: On each valid sample, the comparator level becomes 1 when the sample is strictly greater than the upper threshold. It becomes 0 when the sample is strictly less than the lower threshold. Otherwise, including a sample exactly equal to either threshold, it keeps its previous level. The level is 0 after reset.
- R2: Only a 0-to-1 step of the comparator level between consecutive valid samples is a crossing. After reset or after a timeout, the first crossing only starts the measurement and produces no estimate.
- R3: The period of one input cycle is the number of valid samples from one crossing to the next (the difference of their sample indices). An estimate equals floor(RATE × N / S), where S is the sum of the last N periods and RATE defaults to 16384.
- R4: The averaging input gives N (1 to 15, with a value of 0 treated as 1). It is captured when a measurement window starts, and one estimate is reported per N crossings.
- R5: The frequency output changes only together with the one-cycle update strobe, or on a timeout. It holds its value between crossings, and the strobe is never high on two consecutive cycles.
- R6: While measuring, the 2^CNT_W-th consecutive valid sample without a crossing causes a timeout. The no-signal flag is raised, the frequency output is forced to 0, no strobe is given, and the next crossing re-arms the measurement as in R2.
- R7: After reset the frequency output is 0, the no-signal flag is 1 and the strobe is 0.
- R8: When the upper threshold is less than or equal to the lower threshold, the configuration-error flag is 1 and the comparator keeps its level, so that no crossing is found.
- R9: Each update strobe clears the no-signal flag.
- R10: Input data presented while the valid strobe is low has no effect on the comparator, the interval count or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid_i | input | 1 | Marks a new sample on smp_data_i |
| smp_data_i | input | 16 | Signed ADC sample |
| thr_hi_i | input | 16 | Signed upper comparator threshold (nominally +1000) |
| thr_lo_i | input | 16 | Signed lower comparator threshold (nominally -1000) |
| avg_n_i | input | 4 | Number of periods per estimate (0 behaves as 1) |
| freq_o | output | 19 | Held frequency estimate in hertz |
| freq_upd_o | output | 1 | One-cycle strobe when freq_o takes a new estimate |
| no_sig_o | output | 1 | No valid estimate (after reset or timeout) |
| cfg_err_o | output | 1 | Upper threshold not above lower threshold |

## Verification
The embedded assertions check several properties on every cycle. They check that the comparator level is frozen under a bad threshold setting and on cycles with no valid sample, and that a crossing always follows a low level. They check that every reported window covers at least two samples per period, and that the divider never takes a new request while busy and keeps its remainder below the divisor. At the top level they check that the output is held between updates, that the strobe lasts one cycle, and that a timeout zeroes the output. Only the directed scenarios can show the actual numbers: truncated quotients for even, odd and uneven periods, one report per N crossings, the exact sample on which the timeout fires, re-arming without a spurious estimate, and the rejection of waveforms that stay inside the hysteresis band.

// File: rtl/hfm_pkg.sv
// Shared types for the hysteresis frequency meter.
package hfm_pkg;

    // Sequencer state of the restoring divider.
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_STEP = 1'b1
    } hfm_div_state_e;

endpackage

// File: rtl/hfm_comparator.sv
// Hysteresis comparator with rising-step detection.
// Assumes: thresholds are signed and of the sample width. A bad setting
// (hi <= lo) freezes the level. Outputs are registered, one cycle after
// the valid sample.
module hfm_comparator #(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic signed [SMP_W-1:0] data_i,
    input  logic signed [SMP_W-1:0] hi_i,
    input  logic signed [SMP_W-1:0] lo_i,
    output logic                    err_o,
    output logic                    tick_o,
    output logic                    rise_o
);

    logic lvl_q;
    logic lvl_nxt;

    // Threshold setting check.
    assign err_o = (hi_i <= lo_i);

    // Next comparator level from the current sample.
    always_comb begin
        lvl_nxt = lvl_q;
        if (!err_o) begin
            if (data_i > hi_i) begin
                lvl_nxt = 1'b1;
            end else if (data_i < lo_i) begin
                lvl_nxt = 1'b0;
            end
        end
    end

    // Level register and per-sample tick / rising-step pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 1'b0;
            tick_o <= 1'b0;
            rise_o <= 1'b0;
        end else begin
            tick_o <= valid_i;
            rise_o <= valid_i && lvl_nxt && !lvl_q;
            if (valid_i) begin
                lvl_q <= lvl_nxt;
            end
        end
    end

    // R8: a bad threshold setting freezes the level.
    a_r8_hold_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && err_o) |=> $stable(lvl_q));

    // R10: no valid sample, no change and no pulse.
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(lvl_q) && !tick_o && !rise_o));

    // R2: a crossing is always a step from a low level to a high one.
    a_r2_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (lvl_q && tick_o));

endmodule

// File: rtl/hfm_period_acc.sv
// Period counter and window accumulator.
// Counts valid samples between crossings, sums N periods and issues one
// division request per window. Assumes tick/rise come from the
// comparator. Saturation of the counter disarms and pulses timeout_o.
module hfm_period_acc #(
    parameter int CNT_W = 16,
    parameter int AVG_W = 4,
    parameter int DEN_W = CNT_W + 1 + AVG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rise_i,
    input  logic [AVG_W-1:0] avg_n_i,
    output logic             req_o,
    output logic [DEN_W-1:0] sum_o,
    output logic [AVG_W-1:0] navg_o,
    output logic             timeout_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W-1:0] acc_sum;
    logic [AVG_W-1:0] seen;
    logic [AVG_W-1:0] navg_q;
    logic [AVG_W-1:0] navg_eff;
    logic [CNT_W:0]   period;
    logic [DEN_W-1:0] next_sum;
    logic             win_end;

    // Effective averaging count, zero means one.
    assign navg_eff = (avg_n_i == '0) ? AVG_W'(1) : avg_n_i;
    // Length of the period closing at this crossing.
    assign period   = {1'b0, cnt} + (CNT_W+1)'(1);
    assign next_sum = acc_sum + DEN_W'(period);
    assign win_end  = ((seen + AVG_W'(1)) == navg_q);

    // Arming, counting, window summation and request issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            cnt       <= '0;
            acc_sum   <= '0;
            seen      <= '0;
            navg_q    <= AVG_W'(1);
            req_o     <= 1'b0;
            sum_o     <= '0;
            navg_o    <= AVG_W'(1);
            timeout_o <= 1'b0;
        end else begin
            req_o     <= 1'b0;
            timeout_o <= 1'b0;
            if (tick_i) begin
                if (!armed) begin
                    if (rise_i) begin
                        armed   <= 1'b1;
                        cnt     <= '0;
                        acc_sum <= '0;
                        seen    <= '0;
                        navg_q  <= navg_eff;
                    end
                end else if (rise_i) begin
                    cnt <= '0;
                    if (win_end) begin
                        req_o   <= 1'b1;
                        sum_o   <= next_sum;
                        navg_o  <= navg_q;
                        acc_sum <= '0;
                        seen    <= '0;
                        navg_q  <= navg_eff;
                    end else begin
                        acc_sum <= next_sum;
                        seen    <= seen + AVG_W'(1);
                    end
                end else if (cnt == CNT_MAX) begin
                    armed     <= 1'b0;
                    cnt       <= '0;
                    timeout_o <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    // R6: a timeout always leaves the block disarmed.
    a_r6_timeout_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !armed);

    // R3: hysteresis makes every period at least two samples long.
    a_r3_window_min: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (sum_o >= DEN_W'({navg_o, 1'b0})));

    // R4: the reported window count is never zero.
    a_r4_navg_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (navg_o != '0));

endmodule

// File: rtl/hfm_divider.sv
// Restoring divider, one quotient bit per cycle, NUM_W cycles per divide.
// Assumes den_i is nonzero and start_i is only raised while idle.
// quot_o is valid in the cycle done_o is high.
module hfm_divider
    import hfm_pkg::*;
#(
    parameter int NUM_W = 19,
    parameter int DEN_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o
);

    localparam int IDX_W = $clog2(NUM_W + 1);

    hfm_div_state_e   state;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] quo;
    logic [IDX_W-1:0] idx;
    logic [DEN_W:0]   trial;
    logic             q_bit;
    logic [DEN_W-1:0] rem_nxt;

    // One restoring step: shift in next dividend bit, try to subtract.
    always_comb begin
        trial   = {rem, quo[NUM_W-1]};
        q_bit   = (trial >= {1'b0, den_q});
        rem_nxt = q_bit ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    end

    assign busy_o = (state == DIV_STEP);
    assign quot_o = quo;

    // Sequencer: load operands, iterate, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DIV_IDLE;
            rem    <= '0;
            den_q  <= '0;
            quo    <= '0;
            idx    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                DIV_IDLE: begin
                    if (start_i) begin
                        den_q <= den_i;
                        quo   <= num_i;
                        rem   <= '0;
                        idx   <= IDX_W'(NUM_W - 1);
                        state <= DIV_STEP;
                    end
                end
                DIV_STEP: begin
                    rem <= rem_nxt;
                    quo <= {quo[NUM_W-2:0], q_bit};
                    if (idx == '0) begin
                        state  <= DIV_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        idx <= idx - IDX_W'(1);
                    end
                end
                default: state <= DIV_IDLE;
            endcase
        end
    end

    // R3: a new request never lands on a busy divider.
    a_r3_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R3: the partial remainder stays below the divisor while iterating.
    a_r3_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (rem < den_q));

endmodule

// File: rtl/hfm_freq_meter.sv
// Hysteresis sampled frequency meter, top level.
// Comparator -> period accumulator -> restoring divider -> held output.
// Assumes valid samples are spaced so that a divide (NUM_W + 3 cycles)
// finishes within two samples; a request that finds the divider busy is
// dropped.
module hfm_freq_meter #(
    parameter int SMP_W = 16,
    parameter int CNT_W = 16,
    parameter int AVG_W = 4,
    parameter int RATE  = 16384,
    localparam int RATE_W = $clog2(RATE + 1),
    localparam int NUM_W  = RATE_W + AVG_W,
    localparam int DEN_W  = CNT_W + 1 + AVG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid_i,
    input  logic signed [SMP_W-1:0] smp_data_i,
    input  logic signed [SMP_W-1:0] thr_hi_i,
    input  logic signed [SMP_W-1:0] thr_lo_i,
    input  logic [AVG_W-1:0]        avg_n_i,
    output logic [NUM_W-1:0]        freq_o,
    output logic                    freq_upd_o,
    output logic                    no_sig_o,
    output logic                    cfg_err_o
);

    logic             tick;
    logic             rise;
    logic             req;
    logic [DEN_W-1:0] win_sum;
    logic [AVG_W-1:0] win_navg;
    logic             timeout;
    logic             div_busy;
    logic             div_done;
    logic [NUM_W-1:0] div_quot;
    logic [NUM_W-1:0] div_num;

    hfm_comparator #(.SMP_W(SMP_W)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (smp_valid_i),
        .data_i  (smp_data_i),
        .hi_i    (thr_hi_i),
        .lo_i    (thr_lo_i),
        .err_o   (cfg_err_o),
        .tick_o  (tick),
        .rise_o  (rise)
    );

    hfm_period_acc #(.CNT_W(CNT_W), .AVG_W(AVG_W), .DEN_W(DEN_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .rise_i    (rise),
        .avg_n_i   (avg_n_i),
        .req_o     (req),
        .sum_o     (win_sum),
        .navg_o    (win_navg),
        .timeout_o (timeout)
    );

    // Dividend: sample rate scaled by the number of periods in the window.
    assign div_num = NUM_W'(RATE) * NUM_W'(win_navg);

    hfm_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (req && !div_busy),
        .num_i   (div_num),
        .den_i   (win_sum),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quot_o  (div_quot)
    );

    // Output hold register, strobe and no-signal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_o     <= '0;
            freq_upd_o <= 1'b0;
            no_sig_o   <= 1'b1;
        end else begin
            freq_upd_o <= div_done;
            if (div_done) begin
                freq_o   <= div_quot;
                no_sig_o <= 1'b0;
            end else if (timeout) begin
                freq_o   <= '0;
                no_sig_o <= 1'b1;
            end
        end
    end

    // R5: output held unless a result or a timeout arrives.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_done && !timeout) |=> $stable(freq_o));

    // R5: the update strobe lasts exactly one cycle.
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        freq_upd_o |=> !freq_upd_o);

    // R6: a timeout zeroes the output and raises no-signal.
    a_r6_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> ((freq_o == '0) && no_sig_o && !freq_upd_o));

    // R9: a fresh estimate is never flagged as no-signal.
    a_r9_upd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        freq_upd_o |-> !no_sig_o);

endmodule

// File: tb/test_hfm_freq_meter.sv
// Directed bench for hfm_freq_meter; one task per scenario.
module test_hfm_freq_meter;

    localparam int CNT_W = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid_i = 1'b0;
    logic signed [15:0] smp_data_i = '0;
    logic signed [15:0] thr_hi_i = 16'sd1000;
    logic signed [15:0] thr_lo_i = -16'sd1000;
    logic [3:0]         avg_n_i = 4'd1;
    logic [18:0]        freq_o;
    logic               freq_upd_o;
    logic               no_sig_o;
    logic               cfg_err_o;

    int n_chk  = 0;
    int n_fail = 0;
    int upd_cnt = 0;
    bit finished = 1'b0;

    hfm_freq_meter #(.CNT_W(CNT_W)) i_hfm_freq_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .thr_hi_i    (thr_hi_i),
        .thr_lo_i    (thr_lo_i),
        .avg_n_i     (avg_n_i),
        .freq_o      (freq_o),
        .freq_upd_o  (freq_upd_o),
        .no_sig_o    (no_sig_o),
        .cfg_err_o   (cfg_err_o)
    );

    always #10 clk = ~clk;

    // Count update strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && freq_upd_o) upd_cnt <= upd_cnt + 1;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(int v);
        @(negedge clk);
        smp_valid_i = 1'b1;
        smp_data_i  = 16'(v);
        @(negedge clk);
        smp_valid_i = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic gen(int lo_n, int hi_n);
        for (int i = 0; i < lo_n; i++) send(-2000);
        for (int i = 0; i < hi_n; i++) send(2000);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R7 freq", int'(freq_o), 0);
        chk("R7 no_sig", int'(no_sig_o), 1);
        chk("R7 strobe", int'(freq_upd_o), 0);
        chk("R8 no err", int'(cfg_err_o), 0);
    endtask

    task automatic t_square();
        int base;
        do_reset();
        avg_n_i = 4'd1;
        base = upd_cnt;
        gen(8, 8);
        chk("R2 first crossing silent", upd_cnt - base, 0);
        for (int i = 0; i < 3; i++) gen(8, 8);
        chk("R3 strobes P16", upd_cnt - base, 3);
        chk("R3 freq P16", int'(freq_o), 1024);
        chk("R9 no_sig cleared", int'(no_sig_o), 0);
        for (int i = 0; i < 4; i++) send(-2000);
        chk("R5 held mid period", int'(freq_o), 1024);
        chk("R5 no extra strobe", upd_cnt - base, 3);
        do_reset();
        base = upd_cnt;
        for (int i = 0; i < 3; i++) gen(5, 6);
        chk("R3 strobes P11", upd_cnt - base, 2);
        chk("R3 freq P11 truncated", int'(freq_o), 1489);
    endtask

    task automatic t_average();
        int base;
        do_reset();
        avg_n_i = 4'd5;
        base = upd_cnt;
        gen(4, 3);
        gen(4, 4); gen(4, 3); gen(4, 4); gen(4, 3);
        chk("R4 no report before N", upd_cnt - base, 0);
        gen(4, 4);
        chk("R4 one report per N", upd_cnt - base, 1);
        chk("R4 averaged freq", int'(freq_o), 2214);
        do_reset();
        avg_n_i = 4'd0;
        base = upd_cnt;
        for (int i = 0; i < 3; i++) gen(4, 4);
        chk("R4 zero acts as one", upd_cnt - base, 2);
        chk("R4 zero freq", int'(freq_o), 2048);
        avg_n_i = 4'd1;
    endtask

    task automatic t_hysteresis();
        int base;
        do_reset();
        avg_n_i = 4'd1;
        gen(4, 4); gen(4, 4);
        chk("R3 freq before band", int'(freq_o), 2048);
        base = upd_cnt;
        for (int i = 0; i < 20; i++) send((i % 2 == 0) ? -1000 : 1000);
        chk("R1 band samples no crossing", upd_cnt - base, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            smp_data_i = (i % 2 == 0) ? -16'sd3000 : 16'sd3000;
        end
        chk("R10 invalid data ignored", upd_cnt - base, 0);
        send(-2000);
        send(2000);
        chk("R1 R10 one crossing", upd_cnt - base, 1);
        chk("R1 R10 interval 25", int'(freq_o), 655);
    endtask

    task automatic t_cfg_err();
        int base;
        do_reset();
        thr_hi_i = 16'sd0;
        thr_lo_i = 16'sd0;
        @(negedge clk);
        chk("R8 err flag", int'(cfg_err_o), 1);
        base = upd_cnt;
        for (int i = 0; i < 3; i++) gen(4, 4);
        chk("R8 no crossings", upd_cnt - base, 0);
        chk("R8 freq stays", int'(freq_o), 0);
        chk("R8 no_sig stays", int'(no_sig_o), 1);
        thr_hi_i = 16'sd1000;
        thr_lo_i = -16'sd1000;
        @(negedge clk);
        chk("R8 err cleared", int'(cfg_err_o), 0);
    endtask

    task automatic t_timeout();
        int base;
        do_reset();
        avg_n_i = 4'd1;
        gen(4, 4); gen(4, 4);
        chk("R6 pre freq", int'(freq_o), 2048);
        for (int i = 0; i < 1020; i++) send(2000);
        chk("R6 no timeout at 1023", int'(no_sig_o), 0);
        chk("R6 freq kept at 1023", int'(freq_o), 2048);
        base = upd_cnt;
        send(2000);
        chk("R6 timeout at 1024", int'(no_sig_o), 1);
        chk("R6 freq zeroed", int'(freq_o), 0);
        chk("R6 no strobe on timeout", upd_cnt - base, 0);
        gen(4, 4);
        chk("R2 rearm silent", upd_cnt - base, 0);
        chk("R2 still no signal", int'(no_sig_o), 1);
        gen(4, 4);
        chk("R9 estimate after rearm", int'(freq_o), 2048);
        chk("R9 no_sig cleared again", int'(no_sig_o), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_square();
        t_average();
        t_hysteresis();
        t_cfg_err();
        t_timeout();
        summary();
    end

endmodule